// File: doc/BRIEF.md
# Programmed-I/O Byte FIFO with Command Capture

This block sits between a host register port and the data path of a storage bus controller. The host pushes and pops bytes one at a time. The bytes go into a small circular data buffer, which has its own write pointer, read pointer and occupancy count. The controller side can do two things to this buffer. It can drop a two-byte completion response (a status byte and a zero message byte) into it in a single cycle. It can also take the buffered bytes out as a command descriptor.

A capture-mode input steers host writes away from the data buffer and into a separate command buffer, which keeps its own length. This lets a command descriptor be assembled byte by byte after a select-and-stop sequence.

The read side takes a two-bit bus phase. A read during the data-out phase is an illegal programmed-I/O read: it returns zero and still consumes a count. Every successful read raises a one-cycle interrupt pulse.

Top module: `pio_cmd_fifo`

## Requirements
- R1: After reset, count_o is 0, empty_o is 1, overrun_o is 0, irq_o is 0, rd_data_o is 0x00 and cmd_len_o is 0.
- R2: With capture mode off, host writes are stored in order and host reads return them in write order. Each write adds one to count_o and each read with a nonzero count takes one away. A write and a read in the same cycle leave the count unchanged.
- R3: The data buffer accepts at most DEPTH-1 (15) bytes. A host write when count_o is already 15 is dropped: the count and the stored bytes are unchanged, and overrun_o is set. overrun_o stays set until flush_i is pulsed.
- R4: While cap_mode_i is 1, each host write stores its byte in the command buffer at index cmd_len_o and adds one to cmd_len_o. count_o does not change. Writes are dropped once cmd_len_o reaches CMD_DEPTH (16). cmd_clr_i sets cmd_len_o to 0.
- R5: A host read while count_o is nonzero makes irq_o 1 for exactly the following cycle, with the byte on rd_data_o from that same cycle. A read while count_o is 0 changes nothing, and irq_o stays 0.
- R6: When phase_i is 2'b00 (data-out), a read with a nonzero count returns 0x00 and decrements the count, but does not advance the read pointer.
- R7: When the count reaches 0, both pointers return to entry 0. The next byte written is then the next byte read, even after a data-out read has left the pointers apart.
- R8: A pulse on rsp_load_i stores rsp_status_i in entry 0 and 0x00 in entry 1, sets count_o to 2 and rewinds both pointers. The next two reads return the status byte and then 0x00.
- R9: A pulse on cmd_take_i copies the data buffer into the command buffer, with byte 0 forced to 0x00. cmd_len_o becomes the old count. count_o becomes 0 and both pointers are cleared.
- R10: In a cycle where rsp_load_i is 1, a host read and a host write are ignored. No interrupt is raised, rd_data_o keeps its value, and the count becomes 2.
- R11: empty_o is 1 exactly when count_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Host write strobe |
| wr_data_i | input | 8 | Host write byte |
| rd_req_i | input | 1 | Host read strobe |
| phase_i | input | 2 | Bus phase bits; 2'b00 means data-out |
| cap_mode_i | input | 1 | Send host writes to the command buffer |
| rsp_load_i | input | 1 | Load the completion response |
| rsp_status_i | input | 8 | Status byte of the response |
| cmd_take_i | input | 1 | Move the data buffer into the command buffer |
| cmd_clr_i | input | 1 | Clear the command length |
| flush_i | input | 1 | Clear the overrun flag |
| cmd_idx_i | input | CIW (4) | Command buffer read index |
| rd_data_o | output | 8 | Byte returned by the last successful read |
| irq_o | output | 1 | One-cycle pulse after a successful read |
| count_o | output | CW (5) | Data buffer occupancy |
| empty_o | output | 1 | Occupancy is zero |
| overrun_o | output | 1 | Sticky flag for a dropped write |
| cmd_len_o | output | CLW (5) | Command buffer length |
| cmd_data_o | output | 8 | Command byte at cmd_idx_i |

## Verification
The FIFO ordering is first tested with interleaved writes and reads, including a write and a read in the same cycle, which separates correct count arithmetic from a count that updates only one way per cycle. A data-out read is then placed between two normal reads. When the buffer then drains and is refilled, the next byte read tells a design that rewinds its pointers apart from one that only wraps them. A fill to the limit, followed by one more write and a full drain, shows whether the dropped byte slipped into storage. Response loading is applied together with a read and a write in the same cycle, which exposes a wrong priority through the interrupt, the held read byte and the final count.

// File: rtl/pio_fifo_pkg.sv
package pio_fifo_pkg;
  typedef logic [7:0] byte_t;

  localparam logic [1:0] PH_DATA_OUT = 2'b00;

  function automatic logic is_data_out(input logic [1:0] ph);
    return ph == PH_DATA_OUT;
  endfunction
endpackage

// File: rtl/pio_fifo_ctrl.sv
module pio_fifo_ctrl
  import pio_fifo_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_valid_i,
  input  logic          rd_req_i,
  input  logic          data_out_i,
  input  logic          cap_mode_i,
  input  logic          rsp_load_i,
  input  logic          cmd_take_i,
  input  logic          flush_i,
  output logic [AW-1:0] wptr_o,
  output logic [AW-1:0] rptr_o,
  output logic [CW-1:0] count_o,
  output logic          mem_we_o,
  output logic          cap_we_o,
  output logic          pop_o,
  output logic          overrun_o
);
  localparam logic [CW-1:0] LIMIT = CW'(DEPTH - 1);
  localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);

  logic [AW-1:0] wptr_q, rptr_q, wptr_d, rptr_d;
  logic [CW-1:0] count_q, count_d;
  logic          ovr_q;
  logic          host_ok, wr_data_en, wr_acc, ovr_hit, rd_hit, rd_adv;

  // response load and command take override host traffic
  assign host_ok    = !rsp_load_i && !cmd_take_i;
  assign wr_data_en = host_ok && wr_valid_i && !cap_mode_i;
  assign wr_acc     = wr_data_en && (count_q != LIMIT);
  assign ovr_hit    = wr_data_en && (count_q == LIMIT);
  assign rd_hit     = host_ok && rd_req_i && (count_q != '0);
  assign rd_adv     = rd_hit && !data_out_i;

  always_comb begin
    count_d = count_q;
    wptr_d  = wptr_q;
    rptr_d  = rptr_q;
    if (rsp_load_i) begin
      count_d = CW'(2);
      wptr_d  = '0;
      rptr_d  = '0;
    end else if (cmd_take_i) begin
      count_d = '0;
      wptr_d  = '0;
      rptr_d  = '0;
    end else begin
      count_d = count_q + CW'(wr_acc) - CW'(rd_hit);
      if (wr_acc) wptr_d = (wptr_q == LAST) ? '0 : wptr_q + AW'(1);
      if (rd_adv) rptr_d = (rptr_q == LAST) ? '0 : rptr_q + AW'(1);
      if (count_d == '0) begin
        wptr_d = '0;
        rptr_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      wptr_q  <= '0;
      rptr_q  <= '0;
      ovr_q   <= 1'b0;
    end else begin
      count_q <= count_d;
      wptr_q  <= wptr_d;
      rptr_q  <= rptr_d;
      if (flush_i)      ovr_q <= 1'b0;
      else if (ovr_hit) ovr_q <= 1'b1;
    end
  end

  assign wptr_o    = wptr_q;
  assign rptr_o    = rptr_q;
  assign count_o   = count_q;
  assign mem_we_o  = wr_acc;
  assign cap_we_o  = host_ok && wr_valid_i && cap_mode_i;
  assign pop_o     = rd_hit;
  assign overrun_o = ovr_q;

  // R3: occupancy never exceeds the limit
  a_r3_count_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= LIMIT);
  // R3: dropped write leaves count unchanged and flags overrun
  a_r3_drop_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_hit && !rd_hit && !flush_i) |=> ($stable(count_q) && ovr_q));
  // R7: an empty buffer has both pointers at entry 0
  a_r7_rewind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == '0) |-> (wptr_q == '0 && rptr_q == '0));
  // R8: response load leaves two bytes
  a_r8_rsp_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_load_i |=> (count_q == CW'(2) && rptr_q == '0));
  // R9: command take empties the buffer
  a_r9_take_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_take_i && !rsp_load_i) |=> (count_q == '0));
endmodule

// File: rtl/pio_fifo_mem.sv
module pio_fifo_mem
  import pio_fifo_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  byte_t         wdata_i,
  input  logic          rsp_load_i,
  input  byte_t         rsp_status_i,
  output byte_t         mem_o [DEPTH]
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    byte_t ent_q;
    logic  rsp_hit;
    byte_t rsp_val;

    // response occupies entries 0 (status) and 1 (message)
    assign rsp_hit = rsp_load_i && (i < 2);
    assign rsp_val = (i == 0) ? rsp_status_i : 8'h00;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                ent_q <= '0;
      else if (rsp_hit)                           ent_q <= rsp_val;
      else if (!rsp_load_i && we_i && waddr_i == AW'(i)) ent_q <= wdata_i;
    end

    assign mem_o[i] = ent_q;
  end
endmodule

// File: rtl/pio_cmd_buf.sv
module pio_cmd_buf
  import pio_fifo_pkg::*;
#(
  parameter  int DEPTH     = 16,
  parameter  int CMD_DEPTH = 16,
  localparam int CW        = $clog2(DEPTH + 1),
  localparam int CIW       = $clog2(CMD_DEPTH),
  localparam int CLW       = $clog2(CMD_DEPTH + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cap_we_i,
  input  byte_t          wdata_i,
  input  logic           take_i,
  input  logic [CW-1:0]  take_cnt_i,
  input  byte_t          fifo_i [DEPTH],
  input  logic           clr_i,
  input  logic [CIW-1:0] idx_i,
  output logic [CLW-1:0] len_o,
  output byte_t          data_o
);
  localparam logic [CLW-1:0] FULL = CLW'(CMD_DEPTH);

  logic [CLW-1:0] len_q;
  logic           cap_acc;
  byte_t          cmd_q [CMD_DEPTH];

  assign cap_acc = cap_we_i && (len_q != FULL);

  for (genvar i = 0; i < CMD_DEPTH; i++) begin : g_cmd
    byte_t take_val;
    if (i == 0) begin : g_zero
      assign take_val = 8'h00;
    end else if (i < DEPTH) begin : g_copy
      assign take_val = fifo_i[i];
    end else begin : g_pad
      assign take_val = 8'h00;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             cmd_q[i] <= '0;
      else if (take_i)                         cmd_q[i] <= take_val;
      else if (cap_acc && len_q == CLW'(i))    cmd_q[i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      len_q <= '0;
    else if (clr_i)   len_q <= '0;
    else if (take_i)  len_q <= CLW'(take_cnt_i);
    else if (cap_acc) len_q <= len_q + CLW'(1);
  end

  assign len_o  = len_q;
  assign data_o = cmd_q[idx_i];

  // R4: command length is bounded by the buffer size
  a_r4_len_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_q <= FULL);
  // R9: leading command byte is cleared on take
  a_r9_lead_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> (cmd_q[0] == 8'h00));
endmodule

// File: rtl/pio_cmd_fifo.sv
module pio_cmd_fifo
  import pio_fifo_pkg::*;
#(
  parameter  int DEPTH     = 16,
  parameter  int CMD_DEPTH = 16,
  localparam int AW        = $clog2(DEPTH),
  localparam int CW        = $clog2(DEPTH + 1),
  localparam int CIW       = $clog2(CMD_DEPTH),
  localparam int CLW       = $clog2(CMD_DEPTH + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_valid_i,
  input  logic [7:0]     wr_data_i,
  input  logic           rd_req_i,
  input  logic [1:0]     phase_i,
  input  logic           cap_mode_i,
  input  logic           rsp_load_i,
  input  logic [7:0]     rsp_status_i,
  input  logic           cmd_take_i,
  input  logic           cmd_clr_i,
  input  logic           flush_i,
  input  logic [CIW-1:0] cmd_idx_i,
  output logic [7:0]     rd_data_o,
  output logic           irq_o,
  output logic [CW-1:0]  count_o,
  output logic           empty_o,
  output logic           overrun_o,
  output logic [CLW-1:0] cmd_len_o,
  output logic [7:0]     cmd_data_o
);
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          mem_we, cap_we, pop, data_out;
  byte_t         fifo_mem [DEPTH];
  byte_t         rd_q;
  logic          irq_q;

  assign data_out = is_data_out(phase_i);

  pio_fifo_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_valid_i (wr_valid_i),
    .rd_req_i   (rd_req_i),
    .data_out_i (data_out),
    .cap_mode_i (cap_mode_i),
    .rsp_load_i (rsp_load_i),
    .cmd_take_i (cmd_take_i),
    .flush_i    (flush_i),
    .wptr_o     (wptr),
    .rptr_o     (rptr),
    .count_o    (count),
    .mem_we_o   (mem_we),
    .cap_we_o   (cap_we),
    .pop_o      (pop),
    .overrun_o  (overrun_o)
  );

  pio_fifo_mem #(.DEPTH(DEPTH)) i_mem (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (mem_we),
    .waddr_i      (wptr),
    .wdata_i      (wr_data_i),
    .rsp_load_i   (rsp_load_i),
    .rsp_status_i (rsp_status_i),
    .mem_o        (fifo_mem)
  );

  pio_cmd_buf #(.DEPTH(DEPTH), .CMD_DEPTH(CMD_DEPTH)) i_cmd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_we_i   (cap_we),
    .wdata_i    (wr_data_i),
    .take_i     (cmd_take_i && !rsp_load_i),
    .take_cnt_i (count),
    .fifo_i     (fifo_mem),
    .clr_i      (cmd_clr_i),
    .idx_i      (cmd_idx_i),
    .len_o      (cmd_len_o),
    .data_o     (cmd_data_o)
  );

  // illegal data-out read yields zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= pop;
      if (pop) rd_q <= data_out ? 8'h00 : fifo_mem[rptr];
    end
  end

  assign rd_data_o = rd_q;
  assign irq_o     = irq_q;
  assign count_o   = count;
  assign empty_o   = (count == '0);

  // R4: capture-mode writes leave the data count alone
  a_r4_cap_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_mode_i && wr_valid_i && !rd_req_i && !rsp_load_i && !cmd_take_i)
      |=> $stable(count_o));
  // R5: successful read pulses the interrupt
  a_r5_irq_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && count_o != '0 && !rsp_load_i && !cmd_take_i) |=> irq_o);
  // R10: response load suppresses the read
  a_r10_rsp_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_load_i |=> (!irq_o && $stable(rd_data_o)));
endmodule

// File: tb/test_pio_cmd_fifo.sv
`timescale 1ns/1ps
module test_pio_cmd_fifo;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 0, rd_req = 0, cap_mode = 0, rsp_load = 0;
  logic       cmd_take = 0, cmd_clr = 0, flush = 0;
  logic [7:0] wr_data = 0, rsp_status = 0;
  logic [1:0] phase = 2'b01;
  logic [3:0] cmd_idx = 0;
  logic [7:0] rd_data, cmd_data;
  logic       irq, empty, overrun;
  logic [4:0] count, cmd_len;

  int checks = 0, errors = 0, cycles = 0;

  always #2 clk = ~clk;

  pio_cmd_fifo i_pio_cmd_fifo (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .rd_req_i(rd_req), .phase_i(phase), .cap_mode_i(cap_mode),
    .rsp_load_i(rsp_load), .rsp_status_i(rsp_status), .cmd_take_i(cmd_take),
    .cmd_clr_i(cmd_clr), .flush_i(flush), .cmd_idx_i(cmd_idx),
    .rd_data_o(rd_data), .irq_o(irq), .count_o(count), .empty_o(empty),
    .overrun_o(overrun), .cmd_len_o(cmd_len), .cmd_data_o(cmd_data)
  );

  typedef struct packed {
    logic       wr;
    logic [7:0] d;
    logic       rd;
    logic       dout;
    logic [4:0] cnt;
    logic       chk;
    logic [7:0] exp;
  } vec_t;

  // R2 ordering, R6 data-out read, R7 rewind after drain
  localparam vec_t VECS [11] = '{
    '{1'b1, 8'h11, 1'b0, 1'b0, 5'd1, 1'b0, 8'h00},
    '{1'b1, 8'h22, 1'b0, 1'b0, 5'd2, 1'b0, 8'h00},
    '{1'b1, 8'h33, 1'b1, 1'b0, 5'd2, 1'b1, 8'h11},
    '{1'b0, 8'h00, 1'b1, 1'b0, 5'd1, 1'b1, 8'h22},
    '{1'b0, 8'h00, 1'b1, 1'b1, 5'd0, 1'b1, 8'h00},
    '{1'b1, 8'h44, 1'b0, 1'b0, 5'd1, 1'b0, 8'h00},
    '{1'b0, 8'h00, 1'b1, 1'b0, 5'd0, 1'b1, 8'h44},
    '{1'b1, 8'h55, 1'b0, 1'b0, 5'd1, 1'b0, 8'h00},
    '{1'b1, 8'h66, 1'b0, 1'b0, 5'd2, 1'b0, 8'h00},
    '{1'b0, 8'h00, 1'b1, 1'b0, 5'd1, 1'b1, 8'h55},
    '{1'b0, 8'h00, 1'b1, 1'b0, 5'd0, 1'b1, 8'h66}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic host_wr(input logic [7:0] d);
    wr_valid = 1'b1; wr_data = d;
    cyc();
    wr_valid = 1'b0;
  endtask

  task automatic host_rd();
    rd_req = 1'b1;
    cyc();
    rd_req = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected below 20000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] prev;
    #9 rst_n = 1'b1;
    cyc();
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 empty", empty, 1);
    chk("R1 overrun", overrun, 0);
    chk("R1 irq", irq, 0);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 cmd_len", cmd_len, 0);

    // R2 R6 R7 vector walk
    foreach (VECS[k]) begin
      wr_valid = VECS[k].wr; wr_data = VECS[k].d;
      rd_req = VECS[k].rd; phase = VECS[k].dout ? 2'b00 : 2'b01;
      cyc();
      wr_valid = 0; rd_req = 0; phase = 2'b01;
      chk("R2 count", count, VECS[k].cnt);
      chk("R11 empty", empty, VECS[k].cnt == 0);
      if (VECS[k].chk) chk(VECS[k].dout ? "R6 zero read" : "R7 R2 read data",
                           rd_data, VECS[k].exp);
    end

    // R3 fill to limit, then one more write
    for (int i = 0; i < 15; i++) host_wr(8'hA0 + 8'(i));
    chk("R3 count full", count, 15);
    chk("R3 no overrun yet", overrun, 0);
    host_wr(8'hAF);
    chk("R3 count held", count, 15);
    chk("R3 overrun set", overrun, 1);
    for (int i = 0; i < 15; i++) begin
      host_rd();
      chk("R3 drain data", rd_data, 8'hA0 + 8'(i));
      if (i == 0) chk("R5 irq after read", irq, 1);
    end
    cyc();
    chk("R5 irq single cycle", irq, 0);
    chk("R3 drained", count, 0);
    host_rd();
    chk("R5 empty read irq", irq, 0);
    chk("R5 empty read data", rd_data, 8'hAE);
    chk("R3 overrun sticky", overrun, 1);
    flush = 1'b1; cyc(); flush = 1'b0;
    chk("R3 flush clears", overrun, 0);

    // R4 capture mode
    cap_mode = 1'b1;
    host_wr(8'hC1); host_wr(8'hC2); host_wr(8'hC3);
    chk("R4 cmd_len", cmd_len, 3);
    chk("R4 data count untouched", count, 0);
    cmd_idx = 4'd1; #1;
    chk("R4 cmd byte 1", cmd_data, 8'hC2);
    cmd_idx = 4'd2; #1;
    chk("R4 cmd byte 2", cmd_data, 8'hC3);
    for (int i = 0; i < 17; i++) host_wr(8'(i));
    chk("R4 cmd_len saturates", cmd_len, 16);
    cmd_idx = 4'd15; #1;
    chk("R4 last cmd byte", cmd_data, 8'd12);
    cap_mode = 1'b0;
    cmd_clr = 1'b1; cyc(); cmd_clr = 1'b0;
    chk("R4 cmd clear", cmd_len, 0);

    // R9 command take
    host_wr(8'h9A); host_wr(8'h9B); host_wr(8'h9C);
    cmd_take = 1'b1; cyc(); cmd_take = 1'b0;
    chk("R9 count cleared", count, 0);
    chk("R9 empty", empty, 1);
    chk("R9 cmd_len", cmd_len, 3);
    cmd_idx = 4'd0; #1;
    chk("R9 byte0 zero", cmd_data, 8'h00);
    cmd_idx = 4'd1; #1;
    chk("R9 byte1", cmd_data, 8'h9B);
    cmd_idx = 4'd2; #1;
    chk("R9 byte2", cmd_data, 8'h9C);

    // R8 R10 response load against host read and write
    host_wr(8'h77);
    prev = rd_data;
    rsp_load = 1'b1; rsp_status = 8'h5A;
    rd_req = 1'b1; wr_valid = 1'b1; wr_data = 8'h99;
    cyc();
    rsp_load = 1'b0; rd_req = 1'b0; wr_valid = 1'b0;
    chk("R8 count two", count, 2);
    chk("R10 no irq", irq, 0);
    chk("R10 rd_data held", rd_data, prev);
    host_rd();
    chk("R8 status byte", rd_data, 8'h5A);
    host_rd();
    chk("R8 message byte", rd_data, 8'h00);
    chk("R8 drained", count, 0);
    chk("R11 empty after response", empty, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule